// File: doc/BRIEF.md
# Paged Sequential ROM Interface

This block models the control side of a word-wide read-only memory that uses a single 16-bit bus for both addresses and data. An address is written in two bus phases. A high phase supplies the upper page bits and records the chip-enable level. A low phase supplies the lower page bits and the starting word within the page. Once the address is in, the block switches to active mode. After a programmable read latency, each falling edge of the read strobe presents one 16-bit word and moves the in-page word counter forward. The counter wraps at the end of a 256-word page.

The block has three modes: standby, address input and active. Every strobe is sampled in the clock domain, and every analog delay becomes a cycle count.

The storage is a small synthesizable table that is filled at elaboration. It holds 2^SLOT_BITS page images. The 14-bit page number folds onto these images through an XOR of its two 7-bit halves. The bus is split into an input vector, an output vector and an output-enable, so the block can sit inside a larger chip.

Top module: `prom_seq_rom`

## Requirements
- R1: A high-to-low transition of `ale_hi` latches bus bits [6:0] as the upper page half. Bus bits [15:7] of that phase have no effect. The `ce_n` level is recorded at the same transition.
- R2: A high-to-low transition of `ale_lo` loads the word counter from bus bits [8:1] and the lower page half from bus bits [15:9]. Bus bit 0 of that phase has no effect.
- R3: Word w of page {hi,lo} reads as ((s << 8) | w) XOR 16'h5A3C, where s = (hi XOR lo) mod 2^SLOT_BITS (SLOT_BITS defaults to 2).
- R4: A low phase counts only if a high phase has come since the previous counted low phase. An uncounted low phase leaves the page, the counter and the mode unchanged. A high phase alone puts the block in address-input mode, and reads there drive nothing.
- R5: Each counted read latches the word at the counter and then adds one to the counter. After word 255 the next word is word 0 of the same page.
- R6: If `ce_n` was high at the high phase, the block enters standby after the low phase. In standby `ad_oe` stays low and read strobes have no effect.
- R7: `ad_oe` is high only in active mode, only while `rd_n` was low at the previous clock edge, and only while `ale_lo` is low. It falls at the first clock edge after `rd_n` rises, and it falls at once when `ale_lo` rises.
- R8: For LAT_CYC cycles after a counted low phase, read strobes produce no output and do not move the counter.
- R9: `ad_oe` rises exactly ACC_CYC clock edges after the first edge at which a falling `rd_n` is sampled. At that time `ad_out` carries the latched word.
- R10: After reset the block is in standby and `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, recorded at the high address phase |
| ale_hi | input | 1 | High address phase strobe, acts on its falling edge |
| ale_lo | input | 1 | Low address phase strobe, acts on its falling edge; high marks the bus as input |
| rd_n | input | 1 | Read strobe, active low; each falling edge reads one word |
| ad_in | input | 16 | Bus value as seen at the pins |
| ad_out | output | 16 | Read data |
| ad_oe | output | 1 | Bus drive enable for `ad_out` |

## Verification
The bench sweeps all four page images and reads 257 words from starting points that cross the page end. A counter that ran into the next page, or stopped at 255, gives a wrong word at the seam. Repeating an address while flipping the ignored bits (bit 0 of the low phase, bits 15:7 of the high phase) catches a decoder that still uses them: the words it returns belong to another page or start at a shifted offset. Other runs issue reads during the latency window, inside standby, after a high phase alone and after a low phase with no high phase before it. A design that skipped the gating would drive the bus too early or move the counter. A design that accepted a lone low phase would jump to the new address. The enable is also timed edge by edge, which exposes an access delay that is off by one.

// File: rtl/prom_pkg.sv
package prom_pkg;
    // Shared widths, mode encoding and the storage content rule.
    localparam int WORD_W      = 16;
    localparam int HALF_W      = 7;
    localparam int IDX_W       = 8;
    localparam int PAGE_WORDS  = 1 << IDX_W;
    localparam logic [WORD_W-1:0] DATA_SALT = 16'h5A3C;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_ADDR    = 2'd1,
        MODE_ACTIVE  = 2'd2
    } rom_mode_e;

    // Content of word 'word' in page image 'slot'.
    function automatic logic [WORD_W-1:0] cell_value(int unsigned slot, int unsigned word);
        logic [WORD_W-1:0] raw;
        raw = WORD_W'(slot * PAGE_WORDS + word);
        return raw ^ DATA_SALT;
    endfunction
endpackage

// File: rtl/prom_bus_sync.sv
// Samples the strobes and the bus on the clock and flags falling edges.
// Assumes all inputs are already synchronous to clk.
module prom_bus_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale_hi,
    input  logic         ale_lo,
    input  logic         rd_n,
    input  logic         ce_n,
    input  logic [W-1:0] ad_in,
    output logic         hi_fall,
    output logic         lo_fall,
    output logic         rd_fall,
    output logic         rd_low_q,
    output logic         ce_q,
    output logic [W-1:0] ad_q
);
    logic ale_hi_q, ale_lo_q, rd_q;

    // Previous-cycle copies of the strobes and the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_hi_q <= 1'b0;
            ale_lo_q <= 1'b0;
            rd_q     <= 1'b1;
            ce_q     <= 1'b1;
            ad_q     <= '0;
        end else begin
            ale_hi_q <= ale_hi;
            ale_lo_q <= ale_lo;
            rd_q     <= rd_n;
            ce_q     <= ce_n;
            ad_q     <= ad_in;
        end
    end

    // Falling-edge detection against the live input.
    always_comb begin
        hi_fall  = ale_hi_q & ~ale_hi;
        lo_fall  = ale_lo_q & ~ale_lo;
        rd_fall  = rd_q & ~rd_n;
        rd_low_q = ~rd_q;
    end
endmodule

// File: rtl/prom_addr_regs.sv
// Holds both page halves, the recorded chip enable and the wrapping word
// counter. Assumes a low phase counts only after a high phase.
module prom_addr_regs
    import prom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_fall,
    input  logic              lo_fall,
    input  logic              ce_q,
    input  logic [WORD_W-1:0] ad_q,
    input  logic              advance,
    output logic [HALF_W-1:0] page_hi,
    output logic [HALF_W-1:0] page_lo,
    output logic [IDX_W-1:0]  word_cnt,
    output logic              ce_lat,
    output logic              lo_load
);
    localparam int LO_PAGE_LSB = 1 + IDX_W;

    logic hi_pending;

    // A low phase is accepted only while a high phase is pending.
    always_comb lo_load = lo_fall & hi_pending & ~hi_fall;

    // High phase: upper page half, chip-enable level, pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_hi    <= '0;
            ce_lat     <= 1'b1;
            hi_pending <= 1'b0;
        end else if (hi_fall) begin
            page_hi    <= ad_q[HALF_W-1:0];
            ce_lat     <= ce_q;
            hi_pending <= 1'b1;
        end else if (lo_load) begin
            hi_pending <= 1'b0;
        end
    end

    // Low phase: lower page half; counter preset or in-page increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_lo  <= '0;
            word_cnt <= '0;
        end else if (lo_load) begin
            page_lo  <= ad_q[LO_PAGE_LSB +: HALF_W];
            word_cnt <= ad_q[1 +: IDX_W];
        end else if (advance) begin
            word_cnt <= word_cnt + IDX_W'(1);
        end
    end
endmodule

// File: rtl/prom_cell_array.sv
// Constant page images built at elaboration, with a registered read port.
// Assumes SLOT_BITS stays small so the table fits in a few thousand words.
module prom_cell_array
    import prom_pkg::*;
#(
    parameter int SLOT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_BITS-1:0] slot,
    input  logic [IDX_W-1:0]     word,
    input  logic                 load,
    output logic [WORD_W-1:0]    data_q
);
    localparam int SLOTS   = 1 << SLOT_BITS;
    localparam int ENTRIES = SLOTS * PAGE_WORDS;

    logic [WORD_W-1:0] cells [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        assign cells[i] = cell_value(i / PAGE_WORDS, i % PAGE_WORDS);
    end

    // Capture the addressed word on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= cells[{slot, word}];
    end
endmodule

// File: rtl/prom_seq_rom.sv
// Top: mode control, read latency, access delay and the bus output enable.
// Assumes LAT_CYC >= 1 and ACC_CYC >= 1, both in clock cycles.
module prom_seq_rom
    import prom_pkg::*;
#(
    parameter int LAT_CYC   = 12,
    parameter int ACC_CYC   = 2,
    parameter int SLOT_BITS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        ale_hi,
    input  logic        ale_lo,
    input  logic        rd_n,
    input  logic [15:0] ad_in,
    output logic [15:0] ad_out,
    output logic        ad_oe
);
    localparam int LAT_W = $clog2(LAT_CYC + 1);
    localparam int ACC_W = $clog2(ACC_CYC + 1);

    logic              hi_fall, lo_fall, rd_fall, rd_low_q, ce_q;
    logic [WORD_W-1:0] ad_q;
    logic [HALF_W-1:0] page_hi, page_lo;
    logic [IDX_W-1:0]  word_cnt;
    logic              ce_lat, lo_load, advance, lat_zero, shown;
    logic [LAT_W-1:0]  lat_cnt;
    logic [ACC_W-1:0]  acc_cnt;
    logic [HALF_W-1:0] fold;
    rom_mode_e         mode;

    prom_bus_sync #(.W(WORD_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ale_hi(ale_hi), .ale_lo(ale_lo),
        .rd_n(rd_n), .ce_n(ce_n), .ad_in(ad_in),
        .hi_fall(hi_fall), .lo_fall(lo_fall), .rd_fall(rd_fall),
        .rd_low_q(rd_low_q), .ce_q(ce_q), .ad_q(ad_q)
    );

    prom_addr_regs u_addr (
        .clk(clk), .rst_n(rst_n), .hi_fall(hi_fall), .lo_fall(lo_fall),
        .ce_q(ce_q), .ad_q(ad_q), .advance(advance),
        .page_hi(page_hi), .page_lo(page_lo), .word_cnt(word_cnt),
        .ce_lat(ce_lat), .lo_load(lo_load)
    );

    // Page folding onto the stored images and the read-accept condition.
    always_comb begin
        fold     = page_hi ^ page_lo;
        lat_zero = (lat_cnt == '0);
        advance  = rd_fall & (mode == MODE_ACTIVE) & lat_zero & ~ale_lo & ~hi_fall;
    end

    prom_cell_array #(.SLOT_BITS(SLOT_BITS)) u_cells (
        .clk(clk), .rst_n(rst_n), .slot(fold[SLOT_BITS-1:0]),
        .word(word_cnt), .load(advance), .data_q(ad_out)
    );

    // Mode sequencing: high phase -> address input, counted low phase -> active or standby.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= MODE_STANDBY;
        else if (hi_fall) mode <= MODE_ADDR;
        else if (lo_load) mode <= ce_lat ? MODE_STANDBY : MODE_ACTIVE;
    end

    // Read latency countdown started by each counted low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)             lat_cnt <= '0;
        else if (lo_load)       lat_cnt <= LAT_W'(LAT_CYC);
        else if (!lat_zero)     lat_cnt <= lat_cnt - LAT_W'(1);
    end

    // Access delay countdown per accepted read, held while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                          acc_cnt <= '0;
        else if (advance)                    acc_cnt <= ACC_W'(ACC_CYC);
        else if (acc_cnt != '0 && rd_low_q)  acc_cnt <= acc_cnt - ACC_W'(1);
    end

    // Marks that the data register holds a word for the current address.
    always_ff @(posedge clk) begin
        if (!rst_n)                  shown <= 1'b0;
        else if (advance)            shown <= 1'b1;
        else if (hi_fall || lo_load) shown <= 1'b0;
    end

    // Drive enable for the read data.
    always_comb begin
        ad_oe = (mode == MODE_ACTIVE) & lat_zero & rd_low_q & ~ale_lo
              & (acc_cnt == '0) & shown;
    end
endmodule

// File: rtl/prom_seq_rom_chk.sv
// Property checker attached to every instance of the top module.
module prom_seq_rom_chk
    import prom_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              ad_oe,
    input rom_mode_e         mode,
    input logic              lat_zero,
    input logic              advance,
    input logic              hi_fall,
    input logic              lo_fall,
    input logic              lo_load,
    input logic              ce_lat,
    input logic [HALF_W-1:0] page_hi,
    input logic [HALF_W-1:0] page_lo,
    input logic [IDX_W-1:0]  word_cnt
);
    AST_HI_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_fall |=> $stable(page_hi)); // R1
    AST_LONE_LO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_fall && !lo_load && !advance) |=> ($stable(page_lo) && $stable(word_cnt))); // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !lo_load && word_cnt == 8'hFF) |=> (word_cnt == 8'h00)); // R5
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !lo_load) |=> (word_cnt == IDX_W'($past(word_cnt) + 1))); // R5
    AST_CE_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_load && ce_lat && !hi_fall) |=> (mode == MODE_STANDBY)); // R6
    AST_OE_AFTER_RD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(!rd_n)); // R7
    AST_OE_AFTER_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (mode == MODE_ACTIVE && lat_zero)); // R8
    AST_NO_READ_IN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_zero |-> !advance); // R8
endmodule

bind prom_seq_rom prom_seq_rom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .ad_oe(ad_oe), .mode(mode),
    .lat_zero(lat_zero), .advance(advance), .hi_fall(hi_fall),
    .lo_fall(lo_fall), .lo_load(lo_load), .ce_lat(ce_lat),
    .page_hi(page_hi), .page_lo(page_lo), .word_cnt(word_cnt)
);

// File: tb/prom_seq_rom_test.sv
`timescale 1ns/1ps
module prom_seq_rom_test;
    localparam int LAT = 12;
    localparam int ACC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, ale_hi = 1'b0, ale_lo = 1'b0, rd_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prom_seq_rom #(.LAT_CYC(LAT), .ACC_CYC(ACC), .SLOT_BITS(2)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ale_hi(ale_hi), .ale_lo(ale_lo),
        .rd_n(rd_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    function automatic logic [15:0] expect_word(logic [6:0] hi, logic [6:0] lo, int w);
        logic [1:0] s;
        s = 2'(hi ^ lo);
        return 16'(int'(s) * 256 + (w % 256)) ^ 16'h5A3C;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic phase_hi(logic [15:0] v, logic ce);
        @(negedge clk); ale_hi = 1'b1; ad_in = v; ce_n = ce;
        repeat (2) @(negedge clk);
        ale_hi = 1'b0;
        repeat (2) @(negedge clk);
        ad_in = '0;
    endtask

    task automatic phase_lo(logic [15:0] v);
        @(negedge clk); ale_lo = 1'b1; ad_in = v;
        repeat (2) @(negedge clk);
        ale_lo = 1'b0;
        repeat (2) @(negedge clk);
        ad_in = '0;
    endtask

    task automatic open_page(logic [15:0] hv, logic [15:0] lv, logic ce);
        phase_hi(hv, ce);
        phase_lo(lv);
        repeat (LAT + 2) @(negedge clk);
    endtask

    // One read cycle; returns enable just before and at the access point.
    task automatic read_word(output bit early, output bit oe, output logic [15:0] d);
        @(negedge clk); rd_n = 1'b0;
        repeat (ACC) @(posedge clk);
        @(negedge clk); early = ad_oe;
        @(posedge clk);
        @(negedge clk); oe = ad_oe; d = ad_out;
        rd_n = 1'b1;
    endtask

    function automatic logic [15:0] lo_addr(logic [6:0] lo, int w, bit b0);
        return {lo, 8'(w), b0};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        bit e, o;
        logic [15:0] d, d2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ad_oe == 1'b0, "R10 reset oe", 32'(ad_oe), 0);
        read_word(e, o, d);
        check(o == 1'b0, "R10 read in reset standby", 32'(o), 0);

        // Sweep all page images across the page end (R3, R5, R9).
        for (int h = 0; h < 4; h++) begin
            logic [6:0] hi = 7'(h), lo = 7'd1;
            int start = 200 + h * 13;
            open_page({9'd0, hi}, lo_addr(lo, start, 1'b0), 1'b0);
            for (int k = 0; k < 257; k++) begin
                read_word(e, o, d);
                if (k == 0) check(e == 1'b0, "R9 oe early", 32'(e), 0);
                check(o == 1'b1 && d == expect_word(hi, lo, start + k),
                      ((start + k) % 256 == 0) ? "R5 wrap word" : "R3 data",
                      {15'd0, o, d}, {16'd1, expect_word(hi, lo, start + k)});
                @(negedge clk);
                if (k == 0) check(ad_oe == 1'b0, "R7 oe drop after rd high", 32'(ad_oe), 0);
            end
        end

        // High-phase upper bits ignored (R1).
        open_page(16'hFF80 | 16'd2, lo_addr(7'd0, 17, 1'b0), 1'b0);
        read_word(e, o, d);
        check(o && d == expect_word(7'd2, 7'd0, 17), "R1 upper bits ignored", 32'(d), 32'(expect_word(7'd2, 7'd0, 17)));

        // Low-phase bit 0 ignored (R2).
        open_page(16'd3, lo_addr(7'd5, 40, 1'b1), 1'b0);
        read_word(e, o, d);
        check(o && d == expect_word(7'd3, 7'd5, 40), "R2 bit0 ignored", 32'(d), 32'(expect_word(7'd3, 7'd5, 40)));

        // Lone low phase ignored; counter keeps going (R4).
        phase_lo(lo_addr(7'd9, 100, 1'b0));
        read_word(e, o, d);
        check(o && d == expect_word(7'd3, 7'd5, 41), "R4 lone low phase", 32'(d), 32'(expect_word(7'd3, 7'd5, 41)));

        // High phase alone: address input mode, nothing driven (R4).
        phase_hi(16'd1, 1'b0);
        repeat (LAT + 2) @(negedge clk);
        read_word(e, o, d);
        check(o == 1'b0, "R4 high phase only", 32'(o), 0);

        // Read during latency: no output and no advance (R8).
        phase_lo(lo_addr(7'd0, 60, 1'b0));
        read_word(e, o, d);
        check(o == 1'b0, "R8 oe during latency", 32'(o), 0);
        repeat (LAT + 2) @(negedge clk);
        read_word(e, o, d);
        check(o && d == expect_word(7'd1, 7'd0, 60), "R8 no advance in latency", 32'(d), 32'(expect_word(7'd1, 7'd0, 60)));

        // ALEL rising releases the bus at once (R7).
        @(negedge clk); rd_n = 1'b0;
        repeat (ACC + 1) @(negedge clk);
        check(ad_oe == 1'b1, "R7 oe while reading", 32'(ad_oe), 1);
        ale_lo = 1'b1; ad_in = 16'h0001;
        #1;
        check(ad_oe == 1'b0, "R7 oe off when ale_lo high", 32'(ad_oe), 0);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); ale_lo = 1'b0;
        repeat (2) @(negedge clk);
        read_word(e, o, d2);
        check(o && d2 == expect_word(7'd1, 7'd0, 62), "R7 counter after interrupted read", 32'(d2), 32'(expect_word(7'd1, 7'd0, 62)));

        // Chip enable high at the high phase: standby (R6).
        open_page(16'd0, lo_addr(7'd0, 5, 1'b0), 1'b1);
        for (int k = 0; k < 3; k++) begin
            read_word(e, o, d);
            check(o == 1'b0, "R6 standby read", 32'(o), 0);
        end
        open_page(16'd0, lo_addr(7'd0, 5, 1'b0), 1'b0);
        read_word(e, o, d);
        check(o && d == expect_word(7'd0, 7'd0, 5), "R6 wake from standby", 32'(d), 32'(expect_word(7'd0, 7'd0, 5)));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule